// File: doc/BRIEF.md
# Battery Reset and Lockout Sequencer

This block supervises a battery-powered subsystem. It takes five single-bit level flags from analog comparators (battery above the power-good level, battery above the reset-release level, battery above the lockout-release level, battery below the cutoff, and core supply above its reset threshold). From them it produces a power-good indication, an active-high processor reset, a lockout indication and a regulator enable.

Every flag is brought into the clock domain by a two-flop synchroniser. A prescaler turns the fast reference clock into a slow tick, nominally 32.768 kHz. The tick times two intervals. The first is the glitch window: the core supply must stay low for that window before it counts. The second is the reset stretch that follows recovery.

A four-state sequencer ties these together. The states are LOCKOUT, WAIT_LEVEL, RESET_HOLD and RUN. LOCKOUT gives hysteresis between the cutoff and the lockout-release level. WAIT_LEVEL holds the processor in reset until the higher release level is reached.

Top module: `batt_supervisor`

## Requirements
- R1: `pgood_o` is high exactly when the synchronised power-good flag is high and the block is not in lockout.
- R2: `cpu_rst_o` is high in every state except RUN. A qualified core-supply loss moves RUN to RESET_HOLD on the next clock.
- R3: Once the core supply is back, `cpu_rst_o` stays high for at least `HOLD_TICKS` ticks and at most `HOLD_TICKS`+1 ticks plus synchroniser delay. `HOLD_TICKS` defaults to ceil(50 ms × 32768 Hz) = 1639.
- R4: A core-supply low that spans fewer than `GLITCH_TICKS` ticks does not assert reset. `GLITCH_TICKS` defaults to ceil(64 µs × 32768 Hz) = 3.
- R5: A synchronised cutoff flag forces LOCKOUT on the next clock from any state. In LOCKOUT, `lockout_o`=1, `reg_en_o`=0 and `cpu_rst_o`=1.
- R6: LOCKOUT is left only when the synchronised lockout-release flag is high and the cutoff flag is low. The next state is WAIT_LEVEL.
- R7: In WAIT_LEVEL, reset stays asserted until the synchronised reset-release flag is high. The block then enters RESET_HOLD; it never goes from LOCKOUT straight to RUN.
- R8: Each input reaches the decision logic through exactly two flops. A change driven before clock edge n is visible on the outputs after edge n+1.
- R9: An asynchronous reset (`rst_ni` low) puts the block in LOCKOUT, with `pgood_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| batt_pg_i | input | 1 | Battery above power-good level |
| batt_rel_i | input | 1 | Battery above reset-release level |
| batt_unlock_i | input | 1 | Battery above lockout-release level |
| batt_cut_i | input | 1 | Battery below cutoff |
| vcore_ok_i | input | 1 | Core supply above reset threshold |
| pgood_o | output | 1 | Power-good indication |
| cpu_rst_o | output | 1 | Processor reset, active high |
| lockout_o | output | 1 | Undervoltage lockout active |
| reg_en_o | output | 1 | Regulator enable |

## Verification
The bench builds the block with `PRESCALE`=4, `GLITCH_TICKS`=3 and `HOLD_TICKS`=8. With these values a tick lasts four clocks, and the whole reset stretch finishes in a few dozen cycles. This makes it practical to run many transitions in one run: full recovery from lockout, a supply dip shorter than the glitch window, a sustained supply loss, cutoff while running, and a long wait below the release level. The same short tick also lets the bench measure the hold window to the cycle and check the two-cycle synchroniser latency directly.

// File: rtl/bsv_pkg.sv
package bsv_pkg;
  typedef enum logic [1:0] {
    ST_LOCKOUT    = 2'd0,
    ST_WAIT_LEVEL = 2'd1,
    ST_RESET_HOLD = 2'd2,
    ST_RUN        = 2'd3
  } sup_state_e;

  localparam int unsigned FLAG_PG     = 0;
  localparam int unsigned FLAG_REL    = 1;
  localparam int unsigned FLAG_UNLOCK = 2;
  localparam int unsigned FLAG_CUT    = 3;
  localparam int unsigned FLAG_VOK    = 4;
  localparam int unsigned NUM_FLAGS   = 5;
endpackage

// File: rtl/bsv_sync.sv
module bsv_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/bsv_tick.sv
module bsv_tick #(
  parameter int unsigned PRESCALE = 6104
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/bsv_glitch.sv
module bsv_glitch #(
  parameter int unsigned GLITCH_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic low_i,
  output logic bad_o
);
  localparam int unsigned GW = $clog2(GLITCH_TICKS + 1);
  localparam logic [GW-1:0] LAST = GW'(GLITCH_TICKS - 1);

  logic [GW-1:0] cnt_q;
  logic          bad_q;

  // low must persist across GLITCH_TICKS ticks before it is acted on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (!low_i) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (tick_i && !bad_q) begin
      if (cnt_q == LAST) bad_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/batt_supervisor.sv
module batt_supervisor
  import bsv_pkg::*;
#(
  parameter int unsigned PRESCALE     = 6104,
  parameter int unsigned GLITCH_TICKS = 3,
  parameter int unsigned HOLD_TICKS   = 1639,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic batt_pg_i,
  input  logic batt_rel_i,
  input  logic batt_unlock_i,
  input  logic batt_cut_i,
  input  logic vcore_ok_i,
  output logic pgood_o,
  output logic cpu_rst_o,
  output logic lockout_o,
  output logic reg_en_o
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
  logic pg_s, rel_s, unlock_s, cut_s, vok_s;
  logic tick, supply_bad;

  assign raw_flags[FLAG_PG]     = batt_pg_i;
  assign raw_flags[FLAG_REL]    = batt_rel_i;
  assign raw_flags[FLAG_UNLOCK] = batt_unlock_i;
  assign raw_flags[FLAG_CUT]    = batt_cut_i;
  assign raw_flags[FLAG_VOK]    = vcore_ok_i;

  bsv_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_flags),
    .q_o    (sync_flags)
  );

  assign pg_s     = sync_flags[FLAG_PG];
  assign rel_s    = sync_flags[FLAG_REL];
  assign unlock_s = sync_flags[FLAG_UNLOCK];
  assign cut_s    = sync_flags[FLAG_CUT];
  assign vok_s    = sync_flags[FLAG_VOK];

  bsv_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  bsv_glitch #(.GLITCH_TICKS(GLITCH_TICKS)) u_glitch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .low_i  (!vok_s),
    .bad_o  (supply_bad)
  );

  sup_state_e    state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    if (cut_s && state_q != ST_LOCKOUT) begin
      state_d = ST_LOCKOUT;
      hold_d  = '0;
    end else begin
      unique case (state_q)
        ST_LOCKOUT: begin
          if (unlock_s && !cut_s) state_d = ST_WAIT_LEVEL;
        end
        ST_WAIT_LEVEL: begin
          if (rel_s) begin
            state_d = ST_RESET_HOLD;
            hold_d  = '0;
          end
        end
        ST_RESET_HOLD: begin
          if (supply_bad) hold_d = '0;
          else if (tick) begin
            if (hold_q == HOLD_LAST) state_d = ST_RUN;
            else                     hold_d  = hold_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (supply_bad) begin
            state_d = ST_RESET_HOLD;
            hold_d  = '0;
          end
        end
        default: state_d = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKOUT;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign lockout_o = (state_q == ST_LOCKOUT);
  assign reg_en_o  = !lockout_o;
  assign cpu_rst_o = (state_q != ST_RUN);
  assign pgood_o   = pg_s && !lockout_o;
endmodule

// File: rtl/batt_supervisor_chk.sv
module batt_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic batt_pg_i,
  input logic pgood_o,
  input logic cpu_rst_o,
  input logic lockout_o,
  input logic reg_en_o,
  input logic cut_s,
  input logic unlock_s,
  input logic supply_bad
);
  AST_CUT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_s |=> (lockout_o && !reg_en_o && cpu_rst_o)); // R5

  AST_UNLOCK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lockout_o) |-> ($past(unlock_s) && !$past(cut_s))); // R6

  AST_NO_DIRECT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |=> cpu_rst_o); // R7

  AST_SUPPLY_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_bad && !cut_s) |=> cpu_rst_o); // R2

  AST_RELEASE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> !$past(supply_bad)); // R3

  AST_PG_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(batt_pg_i, 2)); // R8
endmodule

bind batt_supervisor batt_supervisor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .batt_pg_i  (batt_pg_i),
  .pgood_o    (pgood_o),
  .cpu_rst_o  (cpu_rst_o),
  .lockout_o  (lockout_o),
  .reg_en_o   (reg_en_o),
  .cut_s      (cut_s),
  .unlock_s   (unlock_s),
  .supply_bad (supply_bad)
);

// File: tb/tb_batt_supervisor.sv
module tb_batt_supervisor;
  localparam int PRESC = 4;
  localparam int GLT   = 3;
  localparam int HOLD  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 0, rel = 0, unl = 0, cut = 1, vok = 0;
  logic pgood, crst, lock, regen;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  batt_supervisor #(.PRESCALE(PRESC), .GLITCH_TICKS(GLT), .HOLD_TICKS(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .batt_pg_i(pg), .batt_rel_i(rel), .batt_unlock_i(unl),
    .batt_cut_i(cut), .vcore_ok_i(vok),
    .pgood_o(pgood), .cpu_rst_o(crst), .lockout_o(lock), .reg_en_o(regen)
  );

  // behavioural reference: mode 0 lockout, 1 waiting, 2 holding, 3 running
  int   m_mode = 0, m_ph = 0, m_low = 0, m_hold = 0;
  bit   m_bad = 0;
  bit   d1 [5];
  bit   d2 [5];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_low = 0; m_hold = 0; m_bad = 0;
      foreach (d1[i]) begin d1[i] = 0; d2[i] = 0; end
    end else begin
      bit tk;
      int nmode, nhold, nlow;
      bit nbad;
      tk = (m_ph == PRESC - 1);
      nmode = m_mode; nhold = m_hold; nlow = m_low; nbad = m_bad;
      if (d2[4]) begin nlow = 0; nbad = 0; end
      else if (tk && !m_bad) begin
        if (m_low + 1 >= GLT) nbad = 1; else nlow = m_low + 1;
      end
      if (d2[3] && m_mode != 0) begin nmode = 0; nhold = 0; end
      else if (m_mode == 0) begin if (d2[2] && !d2[3]) nmode = 1; end
      else if (m_mode == 1) begin if (d2[1]) begin nmode = 2; nhold = 0; end end
      else if (m_mode == 2) begin
        if (m_bad) nhold = 0;
        else if (tk) begin
          if (m_hold + 1 >= HOLD) nmode = 3; else nhold = m_hold + 1;
        end
      end else if (m_bad) begin nmode = 2; nhold = 0; end
      m_mode = nmode; m_hold = nhold; m_low = nlow; m_bad = nbad;
      m_ph = tk ? 0 : m_ph + 1;
      d2 = d1;
      d1[0] = pg; d1[1] = rel; d1[2] = unl; d1[3] = cut; d1[4] = vok;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1 pgood", pgood, d2[0] && m_mode != 0);
      chk("R2 reset", crst, m_mode != 3);
      chk("R5 lockout", lock, m_mode == 0);
      chk("R5 reg_en", regen, m_mode != 0);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int n;
    wait_n(3);
    // R9: reset state
    chk("R9 lockout at reset", lock, 1'b1);
    chk("R9 pgood at reset", pgood, 1'b0);
    chk("R9 reset out", crst, 1'b1);
    rst_n = 1'b1;
    wait_n(2);
    // R6: cutoff cleared but no unlock -> stay locked
    cut = 0; vok = 1; pg = 1;
    wait_n(20);
    chk("R6 stays locked", lock, 1'b1);
    chk("R1 pgood masked in lockout", pgood, 1'b0);
    unl = 1;
    wait_n(5);
    chk("R6 left lockout", lock, 1'b0);
    chk("R1 pgood after lockout", pgood, 1'b1);
    // R7: wait without release level
    wait_n(40);
    chk("R7 held below release", crst, 1'b1);
    rel = 1;
    n = 0;
    while (crst && n < 200) begin @(negedge clk); n++; end
    checks++;
    if (n < HOLD * PRESC || n > HOLD * PRESC + PRESC + 3) begin
      fails++;
      $display("FAIL R3 hold cycles: actual %0d expected %0d..%0d", n, HOLD*PRESC, HOLD*PRESC+PRESC+3);
    end
    // R8: two-flop latency on pgood
    pg = 0;
    @(negedge clk);
    chk("R8 pgood after one edge", pgood, 1'b1);
    @(negedge clk);
    chk("R8 pgood after two edges", pgood, 1'b0);
    pg = 1;
    // R4: dip of one tick is ignored
    vok = 0; wait_n(PRESC); vok = 1;
    wait_n(20);
    chk("R4 short dip ignored", crst, 1'b0);
    // R2: sustained loss
    vok = 0; wait_n(GLT * PRESC + PRESC + 4);
    chk("R2 reset on supply loss", crst, 1'b1);
    wait_n(30);
    chk("R2 reset held while low", crst, 1'b1);
    vok = 1;
    n = 0;
    while (crst && n < 200) begin @(negedge clk); n++; end
    checks++;
    if (n < HOLD * PRESC || n > HOLD * PRESC + PRESC + 3) begin
      fails++;
      $display("FAIL R3 hold after dip: actual %0d expected %0d..%0d", n, HOLD*PRESC, HOLD*PRESC+PRESC+3);
    end
    // R5: cutoff while running
    cut = 1; unl = 0; rel = 0;
    wait_n(3);
    chk("R5 lockout on cutoff", lock, 1'b1);
    chk("R5 regs off", regen, 1'b0);
    chk("R5 reset in lockout", crst, 1'b1);
    // R6 with cutoff still set: unlock ignored
    unl = 1; wait_n(10);
    chk("R6 cutoff blocks unlock", lock, 1'b1);
    cut = 0; wait_n(4);
    chk("R6 unlock after cutoff clear", lock, 1'b0);
    wait_n(60);
    chk("R7 no release without level", crst, 1'b1);
    rel = 1;
    wait_n(HOLD * PRESC + PRESC + 4);
    chk("R7 release after level", crst, 1'b0);
    wait_n(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule